// File: doc/BRIEF.md
# I2C Interrupt Code Status Register

This block sits between an I2C master/slave protocol engine and a CPU. The engine raises events, each a small numeric code. The block queues them and shows them to software one at a time through a status register field. It also drives a level interrupt line while a code is on show. Software can wait on the line or poll the field. In either case, a read of the status register returns the code on show, clears it and moves on to the next stored event. Between two stored events the interrupt line drops for one cycle, so an edge-sensitive controller sees every event.

The block also chooses what the receive-data register returns. A status read that hands out a receive-data code (from master or slave) captures the engine's shift register at that moment. The receive-data register then returns that held byte until software reads it. At all other times the register follows the live shift register.

Top module: `i2c_irq_status`

## Requirements
- R1: After reset, irq is 0, stat_code is 0 and stat_ovf is 0.
- R2: Codes are 4 bits wide. 0 means no interrupt. 1 means arbitration lost. 2 is master receive data, 3 is master transmit data, 4 is master command acknowledge, 5 is slave receive data and 6 is slave transmit data. An event sampled on evt_valid when nothing is stored appears on stat_code with irq high two clock edges later, and not one edge later.
- R3: Events are presented in arrival order. irq is high exactly while stat_code is non-zero.
- R4: A status read (stat_rd high) while irq is high makes irq 0 and stat_code 0 from the next cycle.
- R5: If a further event is stored when a code is read, irq stays low for exactly one cycle and then rises with the next code.
- R6: An event with code 0 is ignored and is never presented.
- R7: A status read while irq is low returns 0 and changes nothing, so software can poll.
- R8: The block holds one presented code plus four queued codes. An event arriving when all are in use is dropped and sets stat_ovf. stat_ovf stays set until a status read in a cycle with no new drop.
- R9: An event and a status read in the same cycle are both handled: the presented code is cleared and the new event is queued.
- R10: A status read that clears code 2 or 5 captures shift_in. rxd_out shows the captured byte until the cycle after an rxd_rd strobe.
- R11: When no captured byte is held, rxd_out equals shift_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_valid | input | 1 | Engine event strobe |
| evt_code | input | 4 | Code of the event |
| stat_rd | input | 1 | CPU read strobe for the status register |
| stat_code | output | 4 | Interrupt code field, 0 when idle |
| stat_ovf | output | 1 | Sticky event-drop flag |
| irq | output | 1 | Level interrupt line |
| shift_in | input | 8 | Live contents of the engine shift register |
| rxd_rd | input | 1 | CPU read strobe for the receive-data register |
| rxd_out | output | 8 | Receive-data register value |

## Verification
The assertions assume that stat_rd and rxd_rd are single-cycle strobes sampled on the clock. They also assume that evt_code is meaningful only while evt_valid is high and that evt_valid carries at most one event per cycle. The stimulus drives every input at the falling edge and holds each strobe for exactly one cycle. It sends codes 0 to 6 only, with the code-0 case sent on purpose to show that it is ignored. Read strobes come either from directed steps or from the scoreboard monitor, and the monitor reads only while irq is high. The sustained stream spaces its events widely enough that the queue never overflows, so the drop case is exercised only by its own directed step.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    IRQ_NONE     = 4'd0,
    IRQ_ARB_LOST = 4'd1,
    IRQ_M_RX     = 4'd2,
    IRQ_M_TX     = 4'd3,
    IRQ_M_CMDACK = 4'd4,
    IRQ_S_RX     = 4'd5,
    IRQ_S_TX     = 4'd6
  } irq_code_e;

  function automatic logic is_rx_code(input logic [CODE_W-1:0] c);
    return (c == IRQ_M_RX) || (c == IRQ_S_RX);
  endfunction
endpackage

// File: rtl/irq_evt_fifo.sv
module irq_evt_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full,
  output logic         drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign drop    = push && full && !do_pop;
  assign rdata   = mem_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wr_q == AW'(g))) mem_q[g] <= wdata;
    end
  end

  // R8: the occupancy never goes beyond the storage
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R8: a rejected event leaves the occupancy unchanged
  a_r8_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> $stable(cnt_q));
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import i2c_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              q_empty,
  input  logic [CODE_W-1:0] q_head,
  input  logic              drop,
  output logic              pop,
  output logic              irq,
  output logic [CODE_W-1:0] code,
  output logic              ovf
);
  logic              vld_q, vld_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              ovf_q, ovf_d;
  logic              clr;

  assign clr = rd && vld_q;
  assign pop = !vld_q && !q_empty;

  always_comb begin
    vld_d  = vld_q;
    code_d = code_q;
    if (clr) begin
      vld_d  = 1'b0;
      code_d = '0;
    end else if (pop) begin
      vld_d  = 1'b1;
      code_d = q_head;
    end
    ovf_d = drop ? 1'b1 : (rd ? 1'b0 : ovf_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      code_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      code_q <= code_d;
      ovf_q  <= ovf_d;
    end
  end

  assign irq  = vld_q;
  assign code = code_q;
  assign ovf  = ovf_q;

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd && irq |=> !irq && (code == '0));
  a_r3_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (code != '0));
  a_r7_idle_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !irq |=> $stable(code));
  a_r8_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf);
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !rd |=> ovf);
endmodule

// File: rtl/rx_data_sel.sv
module rx_data_sel #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              rd_rx,
  input  logic [DATA_W-1:0] shift_in,
  output logic [DATA_W-1:0] rx_out
);
  logic              sel_q, sel_d;
  logic [DATA_W-1:0] hold_q, hold_d;

  always_comb begin
    sel_d  = sel_q;
    hold_d = hold_q;
    if (load) begin
      sel_d  = 1'b1;
      hold_d = shift_in;
    end else if (rd_rx) begin
      sel_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      sel_q  <= sel_d;
      hold_q <= hold_d;
    end
  end

  assign rx_out = sel_q ? hold_q : shift_in;

  a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rx_out == $past(shift_in));
  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rx && !load |=> rx_out == shift_in);
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2c_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [CODE_W-1:0] evt_code,
  input  logic              stat_rd,
  output logic [CODE_W-1:0] stat_code,
  output logic              stat_ovf,
  output logic              irq,
  input  logic [DATA_W-1:0] shift_in,
  input  logic              rxd_rd,
  output logic [DATA_W-1:0] rxd_out
);
  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic              q_push, q_pop, q_empty, q_full, q_drop;
  logic [CODE_W-1:0] q_head;
  logic              rx_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign q_push = evt_valid && (evt_code != '0);

  irq_evt_fifo #(.DEPTH(FIFO_DEPTH), .W(CODE_W)) fifo_i (
    .clk(clk), .rst_n(rst_i_n), .push(q_push), .wdata(evt_code),
    .pop(q_pop), .rdata(q_head), .empty(q_empty), .full(q_full),
    .drop(q_drop)
  );

  irq_presenter pres_i (
    .clk(clk), .rst_n(rst_i_n), .rd(stat_rd), .q_empty(q_empty),
    .q_head(q_head), .drop(q_drop), .pop(q_pop), .irq(irq),
    .code(stat_code), .ovf(stat_ovf)
  );

  assign rx_load = stat_rd && irq && is_rx_code(stat_code);

  rx_data_sel #(.DATA_W(DATA_W)) rxsel_i (
    .clk(clk), .rst_n(rst_i_n), .load(rx_load), .rd_rx(rxd_rd),
    .shift_in(shift_in), .rx_out(rxd_out)
  );

  // R5: a code handed out with another waiting leaves a one-cycle low gap
  a_r5_gap: assert property (@(posedge clk) disable iff (!rst_i_n)
    stat_rd && irq && !q_empty |=> !irq ##1 irq);
  // R6: a zero code never enters the queue
  a_r6_zero_ignored: assert property (@(posedge clk) disable iff (!rst_i_n)
    evt_valid && (evt_code == '0) && !q_pop |=> $stable(q_empty));
  a_r8_full_unused: assert property (@(posedge clk) disable iff (!rst_i_n)
    q_drop |-> q_full);
endmodule

// File: tb/i2c_irq_status_tb_top.sv
module i2c_irq_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       evt_valid;
  logic [3:0] evt_code;
  logic       stat_rd;
  logic [3:0] stat_code;
  logic       stat_ovf;
  logic       irq;
  logic [7:0] shift_in;
  logic       rxd_rd;
  logic [7:0] rxd_out;

  logic       man_rd = 1'b0;
  logic       mon_rd = 1'b0;
  logic       auto_rd = 1'b0;
  logic [3:0] exp_q [$];
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;
  assign stat_rd = man_rd | mon_rd;

  i2c_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .stat_rd(stat_rd), .stat_code(stat_code), .stat_ovf(stat_ovf),
    .irq(irq), .shift_in(shift_in), .rxd_rd(rxd_rd), .rxd_out(rxd_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // driver: drives one event and records what the scoreboard should see
  task automatic send(input logic [3:0] c);
    evt_valid = 1'b1;
    evt_code  = c;
    if (c != 4'd0) exp_q.push_back(c);
    tick();
    evt_valid = 1'b0;
    evt_code  = 4'd0;
  endtask

  task automatic rd_expect(input string req);
    logic [3:0] e;
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 4'd0;
    chk(irq == 1'b1, req, irq, 1);
    chk(stat_code == e, req, stat_code, e);
    man_rd = 1'b1;
    tick();
    man_rd = 1'b0;
    chk(irq == 1'b0 && stat_code == 4'd0, "R4", {irq, stat_code}, 0);
  endtask

  // monitor: pops and compares while the sustained stream runs
  initial begin
    forever begin
      logic [3:0] e;
      @(negedge clk);
      mon_rd = 1'b0;
      if (auto_rd && irq) begin
        e = (exp_q.size() != 0) ? exp_q.pop_front() : 4'd0;
        chk(stat_code == e, "R3 order", stat_code, e);
        mon_rd = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_valid = 1'b0; evt_code = 4'd0;
    shift_in = 8'h3C; rxd_rd = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state, R11 live path
    chk(irq == 1'b0, "R1", irq, 0);
    chk(stat_code == 4'd0, "R1", stat_code, 0);
    chk(stat_ovf == 1'b0, "R1", stat_ovf, 0);
    chk(rxd_out == 8'h3C, "R11", rxd_out, 8'h3C);

    // R2 latency and arbitration-lost code
    send(4'd1);
    chk(irq == 1'b0, "R2 early", irq, 0);
    tick();
    chk(irq == 1'b1 && stat_code == 4'd1, "R2", {irq, stat_code}, 5'h11);
    rd_expect("R4");

    // R6 zero code ignored
    send(4'd0);
    repeat (3) tick();
    chk(irq == 1'b0 && stat_code == 4'd0, "R6", {irq, stat_code}, 0);

    // R7 poll while idle
    man_rd = 1'b1; tick(); man_rd = 1'b0;
    chk(irq == 1'b0 && stat_code == 4'd0 && stat_ovf == 1'b0, "R7",
        {stat_ovf, irq, stat_code}, 0);
    send(4'd3);
    tick();
    rd_expect("R7");

    // R5 back-to-back gap
    send(4'd4);
    send(4'd5);
    rd_expect("R5");
    tick();
    chk(irq == 1'b1 && stat_code == 4'd5, "R5", {irq, stat_code}, 5'h15);
    rd_expect("R5");
    chk(rxd_out == shift_in, "R11", rxd_out, shift_in);
    rxd_rd = 1'b1; tick(); rxd_rd = 1'b0;

    // R9 event and read in the same cycle, then R10 capture on code 2
    send(4'd6);
    tick();
    chk(stat_code == 4'd6, "R9", stat_code, 6);
    void'(exp_q.pop_front());
    evt_valid = 1'b1; evt_code = 4'd2; exp_q.push_back(4'd2);
    man_rd = 1'b1;
    tick();
    evt_valid = 1'b0; evt_code = 4'd0; man_rd = 1'b0;
    chk(irq == 1'b0, "R9 clear", irq, 0);
    tick();
    shift_in = 8'hA5;
    rd_expect("R9");
    chk(rxd_out == 8'hA5, "R10", rxd_out, 8'hA5);
    shift_in = 8'h11;
    tick();
    chk(rxd_out == 8'hA5, "R10 hold", rxd_out, 8'hA5);
    rxd_rd = 1'b1; tick(); rxd_rd = 1'b0;
    chk(rxd_out == 8'h11, "R11 release", rxd_out, 8'h11);

    // non-receive code leaves the live path
    send(4'd3);
    tick();
    shift_in = 8'h77;
    rd_expect("R10");
    chk(rxd_out == 8'h77, "R11", rxd_out, 8'h77);

    // R8 overflow: one presented plus four queued, sixth dropped
    for (int i = 1; i <= 6; i++) send(4'(i));
    void'(exp_q.pop_back());
    chk(stat_ovf == 1'b1, "R8 set", stat_ovf, 1);
    for (int i = 0; i < 5; i++) begin
      rd_expect("R8 order");
      if (i == 0) chk(stat_ovf == 1'b0, "R8 clear", stat_ovf, 0);
      if (i < 4) tick();
    end
    repeat (3) tick();
    chk(irq == 1'b0, "R8 dropped", irq, 0);

    // R3 sustained stream through the scoreboard
    auto_rd = 1'b1;
    for (int i = 0; i < 24; i++) begin
      send(4'((i * 5) % 6 + 1));
      repeat (3) tick();
    end
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) tick();
    repeat (4) tick();
    auto_rd = 1'b0;
    chk(exp_q.size() == 0, "R3 drained", exp_q.size(), 0);
    chk(stat_ovf == 1'b0, "R8 no drop", stat_ovf, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule